// File: doc/BRIEF.md
# Multi-Rate Serial Lane Bank Aggregator

This block gathers low-speed serial lanes from front-end devices into the fixed user payload of one link frame. Each frame lasts 25 ns. The lanes are grouped into five banks. Each bank can be set on its own to run eight lanes at 80 Mbps, four lanes at 160 Mbps or two lanes at 320 Mbps. Whatever the setting, every bank fills exactly 16 payload bits per frame, so the 80-bit payload layout never changes. A separate slow-control lane at a fixed 80 Mbps adds two bits per frame in its own output field.

The block runs on one clock with four cycles per frame. That is 160 MHz, the clock of the fastest lane. Lane data reach the block as double-data-rate pairs that have already been split: `lane_rise` holds the rising-edge sample and `lane_fall` holds the falling-edge sample of the same cycle, and the rising sample is the older one. A slower lane is sampled only on the cycles in which it presents a new pair. A frame strobe marks the first cycle of each frame and keeps the internal frame phase aligned. At each frame boundary the finished payload is captured and a one-cycle valid pulse is raised, except for frames that are known to be incomplete or mixed.

Top module: `lane_aggr`

## Requirements
- R1: A frame is four clock cycles, phases 0 to 3. A high `frame_strobe` forces the current cycle to phase 0. The payload is captured on the clock edge that ends phase 3, and the new `payload` and `payload_valid` are visible in the following cycle. `payload` holds its value between captures.
- R2: `payload` is 80 bits wide. Bank b occupies bits [16b+15:16b], with bank 0 in the least significant position. Bank b uses the lane inputs at index 8b+l, where l is the lane number within the bank.
- R3: Rate code 2'b00 (8 lanes at 80 Mbps) samples lanes 0 to 7 once per frame, in phase 3. Lane l fills bits [2l+1:2l] of its bank field, with the rising sample in bit 2l+1.
- R4: Rate code 2'b01 (4 lanes at 160 Mbps) samples lanes 0 to 3 in phases 1 and 3. Lane l fills bits [4l+3:4l], with the oldest bit (the phase-1 rising sample) at bit 4l+3, then in order of age toward bit 4l.
- R5: Rate code 2'b10 (2 lanes at 320 Mbps) samples lanes 0 and 1 in every phase. Lane l fills bits [8l+7:8l], with the oldest bit (the phase-0 rising sample) at bit 8l+7.
- R6: Rate code 2'b11 behaves exactly like 2'b00. This includes change detection, so switching between 2'b00 and 2'b11 is not a rate change.
- R7: Lanes at or beyond the active lane count of a bank have no effect on the payload.
- R8: The slow-control pair is sampled in phase 3 of every frame and appears as `sc_word` = {rise, fall}, independent of the bank settings. It is updated at the same time as `payload`.
- R9: `bank_rate_cfg` (bank b at bits [2b+1:2b]) is taken only at a frame boundary. The frame during which the setting changes is still collected and flagged with the old rate.
- R10: The first frame collected after a rate change produces no valid pulse, and neither does the first frame after reset.
- R11: `payload_valid` is a single-cycle pulse, raised once for every clean frame.
- R12: A `frame_strobe` that arrives while the internal phase is not 0 realigns the frame. The interrupted frame is discarded, and the frame started by the strobe produces no valid pulse.
- R13: During reset, `payload`, `sc_word` and `payload_valid` are zero, and every bank runs at rate code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | Marks phase 0 of a frame |
| bank_rate_cfg | input | 10 | Rate code per bank, 2 bits each |
| lane_rise | input | 40 | Rising-edge sample per lane, 8 per bank |
| lane_fall | input | 40 | Falling-edge sample per lane, 8 per bank |
| sc_rise | input | 1 | Slow-control rising-edge sample |
| sc_fall | input | 1 | Slow-control falling-edge sample |
| payload | output | 80 | Captured frame payload |
| sc_word | output | 2 | Captured slow-control pair |
| payload_valid | output | 1 | One-cycle pulse for a clean frame |

## Verification
The bench drives a different pseudo-random bit on every lane, edge and cycle. It therefore catches a design that samples a slow lane in the wrong phase, swaps the rising and falling samples, or reverses the age order inside a slot: each of these produces a payload that differs in the affected bits. The bench also flips the unused lanes in the two-lane mode, which exposes a bank that reads lane indices it should ignore.

For configuration changes, the bench checks three things. The frame in which the setting moves must still carry the old layout with a valid pulse. The next frame must lose its pulse. A swap between the two equivalent 80 Mbps codes must not lose a pulse, which a design comparing raw codes would get wrong.

Finally, the bench cuts a frame short with an early strobe and expects the realigned frame to be flagged. A design that ignores misalignment would pulse valid on a mix of two frames.

// File: rtl/lagg_pkg.sv
package lagg_pkg;
  localparam int FRAME_CYC = 4;
  localparam int PH_W      = $clog2(FRAME_CYC);
  localparam int LANES_MAX = 2 * FRAME_CYC;
  localparam int BANK_BITS = 2 * LANES_MAX;

  typedef enum logic [1:0] {
    RATE_LO  = 2'b00,
    RATE_MID = 2'b01,
    RATE_HI  = 2'b10
  } rate_e;

  // Map the reserved code onto the lowest rate
  function automatic logic [1:0] norm_rate(input logic [1:0] code);
    return (code == 2'b11) ? RATE_LO : code;
  endfunction

  // A lane presents a fresh pair when the phase bits under its mask are all set
  function automatic logic take_sample(input logic [1:0] r, input logic [PH_W-1:0] ph);
    logic [PH_W-1:0] mask;
    case (r)
      RATE_HI:  mask = '0;
      RATE_MID: mask = PH_W'(FRAME_CYC / 2 - 1);
      default:  mask = PH_W'(FRAME_CYC - 1);
    endcase
    return (ph & mask) == mask;
  endfunction
endpackage

// File: rtl/lagg_frame_ctrl.sv
module lagg_frame_ctrl
  import lagg_pkg::*;
#(
  parameter int N_BANKS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_strobe,
  input  logic [2*N_BANKS-1:0] cfg_norm,
  output logic [PH_W-1:0]      phase,
  output logic                 frame_end,
  output logic [2*N_BANKS-1:0] act_rate,
  output logic                 valid
);
  logic [PH_W-1:0] phase_q;
  logic            dirty_q;
  logic            misalign;

  assign phase     = frame_strobe ? '0 : phase_q;
  assign misalign  = frame_strobe && (phase_q != '0);
  assign frame_end = (phase == PH_W'(FRAME_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= '0;
      dirty_q  <= 1'b1;
      valid    <= 1'b0;
      act_rate <= '0;
    end else begin
      phase_q <= phase + PH_W'(1);
      valid   <= 1'b0;
      if (frame_end) begin
        valid    <= !dirty_q;
        act_rate <= cfg_norm;
        dirty_q  <= (cfg_norm != act_rate);
      end else if (misalign) begin
        dirty_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lagg_bank.sv
module lagg_bank
  import lagg_pkg::*;
#(
  parameter int LANES = LANES_MAX,
  parameter int BITS  = BANK_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      rate,
  input  logic [PH_W-1:0] phase,
  input  logic [LANES-1:0] rise,
  input  logic [LANES-1:0] fall,
  output logic [BITS-1:0] acc_nxt
);
  localparam int N_MID = LANES / 2;
  localparam int N_HI  = LANES / 4;
  localparam int W_MID = BITS / N_MID;
  localparam int W_HI  = BITS / N_HI;

  logic [BITS-1:0] acc_q;

  // Each slot shifts toward its top so the oldest pair ends at the MSB
  always_comb begin
    acc_nxt = acc_q;
    if (take_sample(rate, phase)) begin
      case (rate)
        RATE_HI:
          for (int l = 0; l < N_HI; l++)
            acc_nxt[l*W_HI +: W_HI] = {acc_q[l*W_HI +: W_HI-2], rise[l], fall[l]};
        RATE_MID:
          for (int l = 0; l < N_MID; l++)
            acc_nxt[l*W_MID +: W_MID] = {acc_q[l*W_MID +: W_MID-2], rise[l], fall[l]};
        default:
          for (int l = 0; l < LANES; l++)
            acc_nxt[2*l +: 2] = {rise[l], fall[l]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end
endmodule

// File: rtl/lane_aggr.sv
module lane_aggr
  import lagg_pkg::*;
#(
  parameter int N_BANKS = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_strobe,
  input  logic [2*N_BANKS-1:0]           bank_rate_cfg,
  input  logic [N_BANKS*LANES_MAX-1:0]   lane_rise,
  input  logic [N_BANKS*LANES_MAX-1:0]   lane_fall,
  input  logic                           sc_rise,
  input  logic                           sc_fall,
  output logic [N_BANKS*BANK_BITS-1:0]   payload,
  output logic [1:0]                     sc_word,
  output logic                           payload_valid
);
  logic [2*N_BANKS-1:0]         cfg_norm_w;
  logic [2*N_BANKS-1:0]         act_rate_w;
  logic [PH_W-1:0]              phase_w;
  logic                         frame_end_w;
  logic [N_BANKS*BANK_BITS-1:0] bank_nxt_w;

  lagg_frame_ctrl #(.N_BANKS(N_BANKS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .cfg_norm     (cfg_norm_w),
    .phase        (phase_w),
    .frame_end    (frame_end_w),
    .act_rate     (act_rate_w),
    .valid        (payload_valid)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign cfg_norm_w[2*b +: 2] = norm_rate(bank_rate_cfg[2*b +: 2]);

    lagg_bank #(.LANES(LANES_MAX), .BITS(BANK_BITS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rate    (act_rate_w[2*b +: 2]),
      .phase   (phase_w),
      .rise    (lane_rise[b*LANES_MAX +: LANES_MAX]),
      .fall    (lane_fall[b*LANES_MAX +: LANES_MAX]),
      .acc_nxt (bank_nxt_w[b*BANK_BITS +: BANK_BITS])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      payload <= '0;
      sc_word <= '0;
    end else if (frame_end_w) begin
      payload <= bank_nxt_w;
      sc_word <= {sc_rise, sc_fall};
    end
  end
endmodule

// File: rtl/lane_aggr_chk.sv
module lane_aggr_chk
  import lagg_pkg::*;
#(
  parameter int N_BANKS = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         frame_end_w,
  input logic [2*N_BANKS-1:0]         act_rate_w,
  input logic [2*N_BANKS-1:0]         cfg_norm_w,
  input logic [N_BANKS*BANK_BITS-1:0] payload,
  input logic [1:0]                   sc_word,
  input logic                         payload_valid
);
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    payload_valid |=> !payload_valid);

  assert_valid_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    payload_valid |-> $past(frame_end_w));

  assert_payload_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_w |=> $stable(payload));

  assert_sc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_w |=> $stable(sc_word));

  assert_rate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_w |=> $stable(act_rate_w));

  assert_rate_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_w |=> (act_rate_w == $past(cfg_norm_w)));

  for (genvar b = 0; b < N_BANKS; b++) begin : g_chk
    assert_no_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_rate_w[2*b +: 2] != 2'b11);
  end
endmodule

bind lane_aggr lane_aggr_chk #(.N_BANKS(N_BANKS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_end_w   (frame_end_w),
  .act_rate_w    (act_rate_w),
  .cfg_norm_w    (cfg_norm_w),
  .payload       (payload),
  .sc_word       (sc_word),
  .payload_valid (payload_valid)
);

// File: tb/test_lane_aggr.sv
module test_lane_aggr;
  localparam int CLK_PERIOD = 6;
  localparam int NB = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_strobe = 1'b0;
  logic [9:0]  bank_rate_cfg = '0;
  logic [39:0] lane_rise = '0;
  logic [39:0] lane_fall = '0;
  logic        sc_rise = 1'b0;
  logic        sc_fall = 1'b0;
  logic [79:0] payload;
  logic [1:0]  sc_word;
  logic        payload_valid;

  int   n_chk = 0;
  int   n_bad = 0;
  int   fr = 1;
  logic [9:0] act_rates = '0;
  bit   flip_unused = 0;
  logic c1_valid = 1'b0;

  lane_aggr i_lane_aggr (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
    .bank_rate_cfg(bank_rate_cfg), .lane_rise(lane_rise), .lane_fall(lane_fall),
    .sc_rise(sc_rise), .sc_fall(sc_fall), .payload(payload),
    .sc_word(sc_word), .payload_valid(payload_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic pbit(int f, int c, int idx, int e);
    int unsigned h;
    h = (32'(f) * 1103 + 32'(c) * 241 + 32'(idx) * 37 + 32'(e) * 19 + 7) * 32'h9E3779B1;
    return h[20];
  endfunction

  function automatic int lanes_of(logic [1:0] r);
    return (r == 2'b01) ? 4 : (r == 2'b10) ? 2 : 8;
  endfunction

  function automatic logic [79:0] exp_payload(int f, logic [9:0] rates);
    logic [79:0] e = '0;
    for (int b = 0; b < NB; b++) begin
      int n = lanes_of(rates[2*b +: 2]);
      int s = 8 / n;
      int w = 2 * s;
      int step = 4 / s;
      for (int l = 0; l < n; l++)
        for (int j = 0; j < s; j++) begin
          int c = (j + 1) * step - 1;
          int base = 16 * b + w * l;
          e[base + w - 1 - 2*j] = pbit(f, c, 8*b + l, 0);
          e[base + w - 2 - 2*j] = pbit(f, c, 8*b + l, 1);
        end
    end
    return e;
  endfunction

  task automatic check(string req, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_cycle(int c, bit strobe);
    @(negedge clk);
    if (c == 1) c1_valid = payload_valid;
    frame_strobe = strobe;
    for (int i = 0; i < 40; i++) begin
      bit unused = flip_unused && ((i % 8) >= lanes_of(act_rates[2*(i/8) +: 2]));
      lane_rise[i] = pbit(fr, c, i, 0) ^ unused;
      lane_fall[i] = pbit(fr, c, i, 1) ^ unused;
    end
    sc_rise = pbit(fr, c, 99, 0);
    sc_fall = pbit(fr, c, 99, 1);
  endtask

  // One aligned frame; checks valid and, if asked, payload and slow-control
  task automatic frame_chk(string req, logic exp_valid, bit chk_data);
    for (int c = 0; c < 4; c++) drive_cycle(c, c == 0);
    @(posedge clk);
    #1;
    check({req, " valid"}, 80'(payload_valid), 80'(exp_valid));
    if (chk_data) begin
      check({req, " payload"}, payload, exp_payload(fr, act_rates));
      check("R8 sc_word", 80'(sc_word), 80'({pbit(fr, 3, 99, 0), pbit(fr, 3, 99, 1)}));
    end
    act_rates = bank_rate_cfg;
    fr++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R13 payload", payload, '0);
    check("R13 sc_word", 80'(sc_word), '0);
    check("R13 valid", 80'(payload_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    act_rates = '0;
    frame_chk("R10 first after reset", 1'b0, 0);
    frame_chk("R3 R2 all low rate", 1'b1, 1);
    frame_chk("R1 R3 second frame", 1'b1, 1);
    check("R11 pulse dropped", 80'(c1_valid), '0);
  endtask

  // Setting changes in frame B: B keeps old layout, C is flagged, D valid
  task automatic t_mode(string req, logic [9:0] rates);
    bank_rate_cfg = rates;
    frame_chk("R9 old rate during change", 1'b1, 1);
    frame_chk("R10 first after change", 1'b0, 0);
    frame_chk(req, 1'b1, 1);
    frame_chk(req, 1'b1, 1);
  endtask

  task automatic t_reserved();
    t_mode("R3 back to low", 10'b00_00_00_00_00);
    bank_rate_cfg = 10'b11_11_11_11_11;
    frame_chk("R6 no change seen", 1'b1, 1);
    frame_chk("R6 reserved as low", 1'b1, 1);
  endtask

  task automatic t_unused();
    t_mode("R5 all high", 10'b10_10_10_10_10);
    flip_unused = 1;
    frame_chk("R7 unused lanes flipped", 1'b1, 1);
    flip_unused = 0;
  endtask

  task automatic t_realign();
    drive_cycle(0, 1);
    drive_cycle(1, 0);
    frame_chk("R12 realigned frame", 1'b0, 0);
    frame_chk("R12 after realign", 1'b1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mode("R4 all mid", 10'b01_01_01_01_01);
    t_unused();
    t_mode("R2 mixed banks", 10'b01_00_10_01_00);
    t_mode("R5 mixed high", 10'b10_01_00_10_11);
    t_reserved();
    t_realign();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule